// File: doc/BRIEF.md
# Hall Switch Output Stage

This block turns the stream of per-axis field results into a single digital magnetic switch level, as a Hall-effect switch would. Once armed, it watches one axis. The axis is the first one, in X, Y, Z order, whose threshold code is nonzero. On each valid strobe of that axis it decides whether the switch is operated or released. The operate point comes from the axis threshold code. The release point lies a selectable hysteresis band below it. In unipolar form the signed field is compared. In omnipolar form the magnitude is compared, so either pole operates the switch.

The switch is armed only when three conditions hold: a switch mode code is selected, continuous measurement is running, and the hysteresis selection is 2 or above. While armed, the switch takes over the active-low interrupt pin. The normal interrupt level and the pin trigger input are then blocked. When the switch is not armed, the normal interrupt level and the trigger pass straight through, and the switch state is cleared.

Top module: `hall_switch`

## Requirements
- R1: On `sw_mode`, code 5 selects unipolar and code 6 selects omnipolar switching. Every other code (0 to 4, and 7) leaves the switch inactive. While inactive, `pin_n` equals `irq_n_norm` and `trig_gated` equals `trig_pin`.
- R2: The axis watched is the first of X, Y, Z with a nonzero threshold code. Strobes on any other axis leave the switch state unchanged.
- R3: With `hyst_sel` at 0 or 1 the switch is inactive.
- R4: With all three threshold codes zero the switch is inactive.
- R5: With `meas_run` low the switch is inactive.
- R6: While the switch is active, `pin_n` reflects only the switch state and `irq_n_norm` has no effect. `trig_gated` is held at 0.
- R7: Unipolar operate rule. The operate point is the signed 8-bit threshold code times 16, in 12-bit result LSB. A strobed result at or above it turns the switch on. `pin_n` goes to 0 from the clock edge that samples the strobe.
- R8: A strobed result strictly below (operate point minus band) turns the switch off, and `pin_n` goes to 1. A result between the two points leaves the state unchanged.
- R9: The band is 2^(hyst_sel+1) LSB. That is 8 LSB at `hyst_sel`=2, doubling at each step, up to 256 LSB at 7.
- R10: Omnipolar mode applies the R7/R8 rules to the absolute value of the result and the absolute value of the operate point.
- R11: The switch state changes only at an edge where the watched axis's strobe is high. Between strobes it holds.
- R12: The state is cleared whenever the switch is inactive, so re-entering switch mode starts released (`pin_n`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_mode | input | 3 | Interrupt mode code; 5 unipolar, 6 omnipolar |
| meas_run | input | 1 | High while continuous measurement runs |
| hyst_sel | input | 3 | Hysteresis selection |
| thr_x | input | 8 | X threshold code, two's complement |
| thr_y | input | 8 | Y threshold code, two's complement |
| thr_z | input | 8 | Z threshold code, two's complement |
| res_x | input | 12 | X result, two's complement |
| res_y | input | 12 | Y result, two's complement |
| res_z | input | 12 | Z result, two's complement |
| vld_x | input | 1 | X result strobe |
| vld_y | input | 1 | Y result strobe |
| vld_z | input | 1 | Z result strobe |
| irq_n_norm | input | 1 | Normal interrupt level, active low |
| trig_pin | input | 1 | Trigger sampled from the pin |
| pin_n | output | 1 | Interrupt pin level, active low |
| trig_gated | output | 1 | Trigger forwarded to the conversion sequencer |
| sw_active | output | 1 | High while switch mode is armed |

## Verification
The hold property assumes that configuration changes only at a clock where it also re-evaluates arming. It treats a strobe on any axis as a possible update. The bench therefore changes mode, thresholds and hysteresis only between strobes, never in the cycle of a strobe. Strobes are single-cycle pulses on one axis at a time, driven at the falling edge. Each result is driven with its strobe and stays stable until the next one, which keeps every sampled comparison well defined.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    localparam int HYST_W = 3;

    typedef enum logic [1:0] {
        SW_NONE = 2'd0,
        SW_UNI  = 2'd1,
        SW_OMNI = 2'd2
    } sw_kind_e;

    localparam logic [2:0] CODE_UNI  = 3'd5;
    localparam logic [2:0] CODE_OMNI = 3'd6;

    function automatic sw_kind_e decode_kind(input logic [2:0] code);
        sw_kind_e k;
        case (code)
            CODE_UNI:  k = SW_UNI;
            CODE_OMNI: k = SW_OMNI;
            default:   k = SW_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/hsw_axis_pick.sv
module hsw_axis_pick #(
    parameter int N_AX  = 3,
    parameter int THR_W = 8,
    parameter int RES_W = 12
) (
    input  logic [N_AX-1:0][THR_W-1:0] thr_vec,
    input  logic [N_AX-1:0][RES_W-1:0] res_vec,
    input  logic [N_AX-1:0]            vld_vec,
    output logic                       any_en,
    output logic [THR_W-1:0]           sel_thr,
    output logic [RES_W-1:0]           sel_res,
    output logic                       sel_vld
);
    // Lowest index wins: walk downwards so index 0 (X) overrides last.
    always_comb begin
        any_en  = 1'b0;
        sel_thr = '0;
        sel_res = '0;
        sel_vld = 1'b0;
        for (int i = N_AX - 1; i >= 0; i--) begin
            if (thr_vec[i] != '0) begin
                any_en  = 1'b1;
                sel_thr = thr_vec[i];
                sel_res = res_vec[i];
                sel_vld = vld_vec[i];
            end
        end
    end
endmodule

// File: rtl/hsw_eval.sv
module hsw_eval
    import hsw_pkg::*;
#(
    parameter int THR_W = 8,
    parameter int RES_W = 12
) (
    input  sw_kind_e           kind,
    input  logic [HYST_W-1:0]  hyst_sel,
    input  logic [THR_W-1:0]   thr,
    input  logic [RES_W-1:0]   res,
    input  logic               cur_on,
    output logic               nxt_on
);
    localparam int EW = RES_W + 2;
    localparam int SH = RES_W - THR_W;

    logic signed [EW-1:0] thr_e, res_e, op_pt, fld, band, rel_pt;

    always_comb begin
        thr_e = {{(EW-THR_W){thr[THR_W-1]}}, thr} << SH;
        res_e = {{(EW-RES_W){res[RES_W-1]}}, res};
        if (kind == SW_OMNI) begin
            op_pt = thr_e[EW-1] ? -thr_e : thr_e;
            fld   = res_e[EW-1] ? -res_e : res_e;
        end else begin
            op_pt = thr_e;
            fld   = res_e;
        end
        band   = {{(EW-1){1'b0}}, 1'b1} << ({1'b0, hyst_sel} + 4'd1);
        rel_pt = op_pt - band;
        if (fld >= op_pt)
            nxt_on = 1'b1;
        else if (fld < rel_pt)
            nxt_on = 1'b0;
        else
            nxt_on = cur_on;
    end
endmodule

// File: rtl/hall_switch.sv
module hall_switch
    import hsw_pkg::*;
#(
    parameter int THR_W = 8,
    parameter int RES_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        sw_mode,
    input  logic              meas_run,
    input  logic [HYST_W-1:0] hyst_sel,
    input  logic [THR_W-1:0]  thr_x,
    input  logic [THR_W-1:0]  thr_y,
    input  logic [THR_W-1:0]  thr_z,
    input  logic [RES_W-1:0]  res_x,
    input  logic [RES_W-1:0]  res_y,
    input  logic [RES_W-1:0]  res_z,
    input  logic              vld_x,
    input  logic              vld_y,
    input  logic              vld_z,
    input  logic              irq_n_norm,
    input  logic              trig_pin,
    output logic              pin_n,
    output logic              trig_gated,
    output logic              sw_active
);
    localparam int N_AX = 3;

    logic [N_AX-1:0][THR_W-1:0] thr_vec;
    logic [N_AX-1:0][RES_W-1:0] res_vec;
    logic [N_AX-1:0]            vld_vec;

    assign thr_vec = {thr_z, thr_y, thr_x};
    assign res_vec = {res_z, res_y, res_x};
    assign vld_vec = {vld_z, vld_y, vld_x};

    logic             any_en, sel_vld, sw_on, nxt_on;
    logic [THR_W-1:0] sel_thr;
    logic [RES_W-1:0] sel_res;
    sw_kind_e         kind;

    hsw_axis_pick #(.N_AX(N_AX), .THR_W(THR_W), .RES_W(RES_W)) u_pick (
        .thr_vec (thr_vec),
        .res_vec (res_vec),
        .vld_vec (vld_vec),
        .any_en  (any_en),
        .sel_thr (sel_thr),
        .sel_res (sel_res),
        .sel_vld (sel_vld)
    );

    assign kind      = decode_kind(sw_mode);
    assign sw_active = (kind != SW_NONE) && meas_run && (hyst_sel > 3'd1) && any_en;

    hsw_eval #(.THR_W(THR_W), .RES_W(RES_W)) u_eval (
        .kind     (kind),
        .hyst_sel (hyst_sel),
        .thr      (sel_thr),
        .res      (sel_res),
        .cur_on   (sw_on),
        .nxt_on   (nxt_on)
    );

    always_ff @(posedge clk) begin
        if (rst || !sw_active)
            sw_on <= 1'b0;
        else if (sel_vld)
            sw_on <= nxt_on;
    end

    assign pin_n      = sw_active ? ~sw_on : irq_n_norm;
    assign trig_gated = trig_pin & ~sw_active;
endmodule

// File: rtl/hall_switch_chk.sv
module hall_switch_chk #(
    parameter int THR_W = 8,
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       sw_mode,
    input logic             meas_run,
    input logic [2:0]       hyst_sel,
    input logic [THR_W-1:0] thr_x,
    input logic [THR_W-1:0] thr_y,
    input logic [THR_W-1:0] thr_z,
    input logic             vld_x,
    input logic             vld_y,
    input logic             vld_z,
    input logic             irq_n_norm,
    input logic             trig_pin,
    input logic             pin_n,
    input logic             trig_gated,
    input logic             sw_active
);
    logic any_vld;
    assign any_vld = vld_x | vld_y | vld_z;

    a_r1_passthru: assert property (@(posedge clk) disable iff (rst)
        (sw_mode != 3'd5 && sw_mode != 3'd6) |-> (pin_n == irq_n_norm && trig_gated == trig_pin));

    a_r3_low_hyst: assert property (@(posedge clk) disable iff (rst)
        (hyst_sel < 3'd2) |-> !sw_active);

    a_r4_no_thr: assert property (@(posedge clk) disable iff (rst)
        (thr_x == '0 && thr_y == '0 && thr_z == '0) |-> !sw_active);

    a_r5_not_running: assert property (@(posedge clk) disable iff (rst)
        !meas_run |-> !sw_active);

    a_r6_trig_blocked: assert property (@(posedge clk) disable iff (rst)
        sw_active |-> (trig_gated == 1'b0));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (sw_active && $past(sw_active) && !$past(any_vld)) |-> $stable(pin_n));
endmodule

bind hall_switch hall_switch_chk #(.THR_W(THR_W), .RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_mode    (sw_mode),
    .meas_run   (meas_run),
    .hyst_sel   (hyst_sel),
    .thr_x      (thr_x),
    .thr_y      (thr_y),
    .thr_z      (thr_z),
    .vld_x      (vld_x),
    .vld_y      (vld_y),
    .vld_z      (vld_z),
    .irq_n_norm (irq_n_norm),
    .trig_pin   (trig_pin),
    .pin_n      (pin_n),
    .trig_gated (trig_gated),
    .sw_active  (sw_active)
);

// File: tb/hall_switch_bench.sv
module hall_switch_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic [2:0]  sw_mode, hyst_sel;
    logic        meas_run;
    logic [7:0]  thr_x, thr_y, thr_z;
    logic [11:0] res_x, res_y, res_z;
    logic        vld_x, vld_y, vld_z, irq_n_norm, trig_pin;
    logic        pin_n, trig_gated, sw_active;

    hall_switch u_hall_switch (
        .clk(clk), .rst(rst), .sw_mode(sw_mode), .meas_run(meas_run),
        .hyst_sel(hyst_sel), .thr_x(thr_x), .thr_y(thr_y), .thr_z(thr_z),
        .res_x(res_x), .res_y(res_y), .res_z(res_z),
        .vld_x(vld_x), .vld_y(vld_y), .vld_z(vld_z),
        .irq_n_norm(irq_n_norm), .trig_pin(trig_pin),
        .pin_n(pin_n), .trig_gated(trig_gated), .sw_active(sw_active)
    );

    int checks = 0;
    int fails  = 0;
    bit exp_on = 1'b0;

    task automatic check(string req, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, expv);
        end
    endtask

    function automatic int sel_axis();
        if (thr_x != 0) return 0;
        if (thr_y != 0) return 1;
        if (thr_z != 0) return 2;
        return -1;
    endfunction

    function automatic bit model_active();
        return (sw_mode == 3'd5 || sw_mode == 3'd6) && meas_run &&
               hyst_sel >= 3'd2 && sel_axis() >= 0;
    endfunction

    function automatic int thr_of(int ax);
        logic [7:0] t;
        t = (ax == 0) ? thr_x : (ax == 1) ? thr_y : thr_z;
        return int'($signed(t)) * 16;
    endfunction

    task automatic check_pins(string req);
        if (model_active()) begin
            check(req, pin_n, ~exp_on);
            check(req, trig_gated, 1'b0);
        end else begin
            check(req, pin_n, irq_n_norm);
            check(req, trig_gated, trig_pin);
        end
    endtask

    // Advance one edge after a configuration change made at a falling edge.
    task automatic settle();
        @(negedge clk);
        if (!model_active()) exp_on = 1'b0;
    endtask

    task automatic strobe(int ax, int val, string req);
        case (ax)
            0: begin res_x = 12'(val); vld_x = 1'b1; end
            1: begin res_y = 12'(val); vld_y = 1'b1; end
            default: begin res_z = 12'(val); vld_z = 1'b1; end
        endcase
        @(negedge clk);
        vld_x = 1'b0; vld_y = 1'b0; vld_z = 1'b0;
        if (!model_active()) exp_on = 1'b0;
        else if (ax == sel_axis()) begin
            int t, f, b;
            t = thr_of(ax);
            f = val;
            b = 1 << (int'(hyst_sel) + 1);
            if (sw_mode == 3'd6) begin
                if (t < 0) t = -t;
                if (f < 0) f = -f;
            end
            if (f >= t) exp_on = 1'b1;
            else if (f < t - b) exp_on = 1'b0;
        end
        check_pins(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; sw_mode = 3'd0; meas_run = 1'b0; hyst_sel = 3'd0;
        thr_x = 0; thr_y = 0; thr_z = 0; res_x = 0; res_y = 0; res_z = 0;
        vld_x = 0; vld_y = 0; vld_z = 0; irq_n_norm = 1'b1; trig_pin = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset pin", pin_n, 1'b1);
        check("R1 reset trig", trig_gated, 1'b0);
        check("R1 reset active", sw_active, 1'b0);

        // R1: every mode code, with the switch otherwise fully armed.
        meas_run = 1'b1; hyst_sel = 3'd4; thr_x = 8'sd20;
        for (int m = 0; m < 8; m++) begin
            sw_mode = 3'(m);
            settle();
            for (int p = 0; p < 4; p++) begin
                irq_n_norm = p[0]; trig_pin = p[1];
                #1;
                check_pins("R1 mode decode");
                check("R1 active flag", sw_active, model_active());
            end
            strobe(0, 2000, "R1 strobe per mode");
            irq_n_norm = 1'b0; trig_pin = 1'b1; #1;
            check_pins("R6 override");
            irq_n_norm = 1'b1; trig_pin = 1'b0;
            strobe(0, -2000, "R1 release per mode");
        end

        // R3 / R5 / R4 gating
        sw_mode = 3'd5;
        for (int h = 0; h < 2; h++) begin
            hyst_sel = 3'(h); settle();
            check("R3 low hysteresis", sw_active, 1'b0);
            strobe(0, 2000, "R3 strobe ignored");
        end
        hyst_sel = 3'd3; meas_run = 1'b0; settle();
        check("R5 not running", sw_active, 1'b0);
        strobe(0, 2000, "R5 strobe ignored");
        meas_run = 1'b1; thr_x = 0; settle();
        check("R4 no threshold", sw_active, 1'b0);
        strobe(0, 2000, "R4 strobe ignored");

        // R2 priority: Y watched, Z strobes ignored; then X takes over.
        thr_y = 8'sd10; thr_z = 8'sd30; settle();
        strobe(2, 2000, "R2 non-selected axis");
        check("R2 pin after Z strobe", pin_n, 1'b1);
        strobe(1, 200, "R2 selected Y operates");
        check("R2 pin after Y strobe", pin_n, 1'b0);
        strobe(2, -2000, "R2 Z release ignored");
        check("R2 still operated", pin_n, 1'b0);
        // Enabling X changes only the watched axis; state persists while active.
        thr_x = 8'sd50; settle();
        strobe(1, -2000, "R2 Y now ignored");
        check("R2 Y ignored once X enabled", pin_n, 1'b0);
        strobe(0, -2000, "R2 X releases");

        // R12: clear on leaving switch mode.
        strobe(0, 2000, "R12 operate");
        sw_mode = 3'd0; settle();
        sw_mode = 3'd5; settle();
        check("R12 restart released", pin_n, 1'b1);

        // R11: hold between strobes.
        strobe(0, 2000, "R11 operate");
        res_x = 12'(-2000);
        repeat (5) @(negedge clk);
        check("R11 hold without strobe", pin_n, 1'b0);
        strobe(0, -2000, "R11 release");
        thr_y = 0; thr_z = 0;

        // R7 R8 R9 R10: boundaries and sweeps for every band and both forms.
        for (int md = 5; md <= 6; md++) begin
            for (int h = 2; h < 8; h++) begin
                int t, b;
                sw_mode = 3'(md); hyst_sel = 3'(h);
                thr_x = (md == 6 && h[0]) ? -8'sd37 : 8'sd37;
                settle();
                t = 592; b = 1 << (h + 1);
                strobe(0, t - 1, "R7 below operate");
                strobe(0, t, "R7 at operate");
                check("R7 operated at threshold", pin_n, 1'b0);
                strobe(0, t - b, "R8 at release holds");
                check("R9 band edge holds", pin_n, 1'b0);
                strobe(0, t - b - 1, "R8 below release");
                check("R9 band edge releases", pin_n, 1'b1);
                strobe(0, t - b, "R8 inside band stays off");
                if (md == 6) begin
                    strobe(0, -t, "R10 opposite pole operates");
                    check("R10 negative pole on", pin_n, 1'b0);
                    strobe(0, -(t - b - 1), "R10 opposite pole releases");
                    check("R10 negative pole off", pin_n, 1'b1);
                end
                for (int v = -2048; v < 2048; v += 13)
                    strobe(0, v, md == 5 ? "R8 unipolar sweep up" : "R10 omnipolar sweep up");
                for (int v = 2047; v >= -2048; v -= 13)
                    strobe(0, v, md == 5 ? "R8 unipolar sweep down" : "R10 omnipolar sweep down");
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule